// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Register Interface

This block is the slave side of an 8-bit multiplexed address/data bus. A single mode input selects one of two strobe conventions. In one convention a data strobe qualified by a direction line runs each transfer. In the other, separate active-low read and write strobes run it. The address travels on the shared lines ahead of each transfer and is captured when the address strobe falls.

The block decodes 128 locations. Three of them have their own access rules: a control byte whose top bit is fixed, a flag byte that can be written only when a particular oscillator code is programmed, and a status byte that is read-only. Every other location is plain storage. Every bus input is brought into the system clock through a two-flop synchroniser and is acted on by edge detection. A write-protect input, held for a set number of cycles after it clears, blocks all writes.

Top module: `mux_bus_regif`

## Requirements
- R1: The falling edge of `as` captures `ad_in[6:0]` as the location, whatever the level of `cs_n`; `ad_in[7]` is ignored, so location 0x85 aliases 0x05.
- R2: With `bus_mode`=1, a read drives `ad_oe`=1 and the addressed byte on `ad_out` while `ds`=1, `rw`=1 and `cs_n`=0. A write captures `ad_in` on the falling edge of `ds` while `rw`=0 and `cs_n`=0.
- R3: With `bus_mode`=0, `ds` is an active-low read strobe: `ad_oe`=1 and the data is valid while `ds`=0 and `cs_n`=0. `rw` is an active-low write strobe, and its rising edge captures `ad_in` while `cs_n`=0.
- R4: Locations 0x00–0x09, 0x0B and 0x0E–0x7F read back the last byte written to them.
- R5: Location 0x0A stores bits 6:0; bit 7 always reads 0 and cannot be written. Its bits 6:4 are the oscillator code.
- R6: A write to location 0x0C takes effect only while the oscillator code (0x0A bits 6:4) is 3'b011. Otherwise the write is ignored and the location keeps its value.
- R7: Location 0x0D reads {`vrt`, 7'b0} and ignores writes.
- R8: While `cs_n`=1, `ad_oe` stays 0 and writes have no effect.
- R9: Writes are ignored while `wp`=1 and for `RECOVER_CYCLES` clock cycles after `wp` returns to 0.
- R10: While `rst_n`=0 the block does not respond: `ad_oe`=0 and no write is taken. Locations 0x0A and 0x0C reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 1 | 1: direction-qualified data strobe, 0: separate read/write strobes |
| cs_n | input | 1 | Active-low chip select |
| as | input | 1 | Address strobe, captures the location on its falling edge |
| ds | input | 1 | Data strobe (mode 1) or active-low read strobe (mode 0) |
| rw | input | 1 | Direction, 1 = read (mode 1), or active-low write strobe (mode 0) |
| ad_in | input | 8 | Shared bus, input side |
| ad_out | output | 8 | Shared bus, output side |
| ad_oe | output | 1 | Output enable for the shared bus |
| wp | input | 1 | Write-protect request |
| vrt | input | 1 | Valid-backup flag, reported in bit 7 of location 0x0D |

## Verification
Each strobe edge takes three clock edges to act: two synchroniser stages and one edge-detect register. An address or a write lands on the third rising edge after the strobe changes. `ad_oe` and read data follow two edges after the strobe, because they are decoded from the second synchroniser stage. The bench therefore holds every bus phase for four cycles, keeps `ad_in` stable through that window, and samples outputs on the falling clock edge at the end of the phase. The protection window is probed once well inside `RECOVER_CYCLES` and once well past it, so the result does not hinge on the exact cycle.

// File: rtl/mux_bus_regif.sv
module mux_bus_regif #(
  parameter int ADDR_W = 7,
  parameter int RECOVER_CYCLES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_mode,
  input  logic       cs_n,
  input  logic       as,
  input  logic       ds,
  input  logic       rw,
  input  logic [7:0] ad_in,
  output logic [7:0] ad_out,
  output logic       ad_oe,
  input  logic       wp,
  input  logic       vrt
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW = $clog2(RECOVER_CYCLES + 1);
  localparam logic [ADDR_W-1:0] LOC_A = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] LOC_C = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] LOC_D = ADDR_W'(13);
  localparam logic [4:0] IDLE = 5'b01100;

  logic [4:0] sy1, sy2, sy3;
  logic [ADDR_W-1:0] addr_q;
  logic [6:0] reg_a;
  logic [7:0] reg_c;
  logic [7:0] mem [DEPTH];
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= IDLE; sy2 <= IDLE; sy3 <= IDLE;
    end else begin
      sy1 <= {wp, cs_n, rw, ds, as};
      sy2 <= sy1;
      sy3 <= sy2;
    end

  wire as_fall = sy3[0] & ~sy2[0];
  wire ds_fall = sy3[1] & ~sy2[1];
  wire rw_rise = ~sy3[2] & sy2[2];
  wire sel     = ~sy2[3];
  wire wp_s    = sy2[4];
  wire prot    = wp_s | (cnt != '0);
  wire strobe  = bus_mode ? (ds_fall & ~sy2[2]) : rw_rise;
  wire we      = strobe & sel & ~prot;

  assign ad_oe = sel & (bus_mode ? (sy2[1] & sy2[2]) : ~sy2[1]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (wp_s) cnt <= CW'(RECOVER_CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) addr_q <= '0;
    else if (as_fall) addr_q <= ad_in[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      reg_a <= '0;
      reg_c <= '0;
    end else if (we) begin
      if (addr_q == LOC_A) reg_a <= ad_in[6:0];
      if (addr_q == LOC_C && reg_a[6:4] == 3'b011) reg_c <= ad_in;
    end

  always_ff @(posedge clk)
    if (we && addr_q != LOC_A && addr_q != LOC_C && addr_q != LOC_D)
      mem[addr_q] <= ad_in;

  always_comb
    case (addr_q)
      LOC_A:   ad_out = {1'b0, reg_a};
      LOC_C:   ad_out = reg_c;
      LOC_D:   ad_out = {vrt, 7'b0};
      default: ad_out = mem[addr_q];
    endcase

  a_r9_protect_a: assert property (@(posedge clk) disable iff (!rst_n)
    prot |=> $stable(reg_a));
  a_r9_protect_c: assert property (@(posedge clk) disable iff (!rst_n)
    prot |=> $stable(reg_c));
  a_r6_c_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_a[6:4] != 3'b011) |=> $stable(reg_c));
  a_r8_no_oe_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    sy2[3] |-> !ad_oe);
  a_r10_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> !ad_oe);
  a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !as_fall |=> $stable(addr_q));
endmodule

// File: tb/test_mux_bus_regif.sv
module test_mux_bus_regif;
  logic clk = 0, rst_n = 0, bus_mode = 1, cs_n = 1, as = 0, ds = 0, rw = 1;
  logic wp = 0, vrt = 1;
  logic [7:0] ad_in = 0;
  logic [7:0] ad_out;
  logic ad_oe;
  int checks = 0, errors = 0;
  logic [7:0] model [128];

  mux_bus_regif i_mux_bus_regif (.clk, .rst_n, .bus_mode, .cs_n, .as, .ds, .rw,
    .ad_in, .ad_out, .ad_oe, .wp, .vrt);

  always #4 clk = ~clk;

  task automatic gap(int n); repeat (n) @(negedge clk); endtask

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_addr(logic [7:0] a);
    ad_in = a; as = 1; gap(4);
    as = 0; gap(4);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, logic sel_n = 0);
    put_addr(a);
    ad_in = d;
    if (bus_mode) begin
      rw = 0; cs_n = sel_n; ds = 1; gap(4);
      ds = 0; gap(4);
      cs_n = 1; rw = 1; gap(4);
    end else begin
      cs_n = sel_n; rw = 0; gap(4);
      rw = 1; gap(4);
      cs_n = 1; gap(4);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic oe, output logic [7:0] d,
                    input logic sel_n = 0);
    put_addr(a);
    cs_n = sel_n;
    if (bus_mode) begin rw = 1; ds = 1; end else ds = 0;
    gap(4);
    oe = ad_oe; d = ad_out;
    ds = bus_mode ? 1'b0 : 1'b1; cs_n = 1; gap(4);
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
    logic oe; logic [7:0] d;
    rd(a, oe, d);
    check(req, {oe, d}, {1'b1, exp});
  endtask

  function automatic logic plain(int a);
    return a != 10 && a != 12 && a != 13;
  endfunction

  initial begin
    gap(2);
    check("R10 reset oe", {8'h0, ad_oe}, 9'h0);
    rst_n = 1; gap(3);

    for (int a = 0; a < 128; a++)
      if (plain(a)) begin model[a] = 8'(a * 7 + 3); wr(8'(a), model[a]); end
    for (int a = 0; a < 128; a++)
      if (plain(a)) rd_chk(a == 11 || a < 10 ? "R4 mode1 clock bytes" : "R2 R4 mode1 storage",
                           8'(a), model[a]);

    wr(8'h85, 8'hC3); model[5] = 8'hC3;
    rd_chk("R1 bit7 aliases", 8'h05, 8'hC3);
    rd_chk("R1 aliased read", 8'h85, 8'hC3);

    wr(8'd10, 8'hFF);
    rd_chk("R5 A msb fixed", 8'd10, 8'h7F);
    wr(8'd12, 8'h55);
    rd_chk("R6 C locked", 8'd12, 8'h00);
    wr(8'd10, 8'h35);
    rd_chk("R5 A low bits", 8'd10, 8'h35);
    wr(8'd12, 8'hA5);
    rd_chk("R6 C open at 011", 8'd12, 8'hA5);
    wr(8'd10, 8'h20);
    wr(8'd12, 8'h00);
    rd_chk("R6 C relocked", 8'd12, 8'hA5);

    rd_chk("R7 D vrt=1", 8'd13, 8'h80);
    vrt = 0; gap(1);
    rd_chk("R7 D vrt=0", 8'd13, 8'h00);
    wr(8'd13, 8'hFF);
    rd_chk("R7 D write ignored", 8'd13, 8'h00);
    vrt = 1;

    wr(8'd40, 8'h11, 1'b1);
    rd_chk("R8 write with cs high", 8'd40, model[40]);
    begin
      logic oe; logic [7:0] d;
      rd(8'd40, oe, d, 1'b1);
      check("R8 no oe with cs high", {8'h0, oe}, 9'h0);
    end

    wp = 1; gap(4);
    wr(8'd20, 8'h99);
    rd_chk("R9 write while wp", 8'd20, model[20]);
    wp = 0;
    wr(8'd20, 8'h98);
    rd_chk("R9 write in recovery", 8'd20, model[20]);
    gap(40);
    wr(8'd20, 8'h97); model[20] = 8'h97;
    rd_chk("R9 write after recovery", 8'd20, 8'h97);

    bus_mode = 0; ds = 1; rw = 1; gap(4);
    for (int a = 0; a < 128; a++)
      if (plain(a)) begin model[a] = 8'(a * 13 + 8'h5A); wr(8'(a), model[a]); end
    for (int a = 0; a < 128; a++)
      if (plain(a)) rd_chk("R3 R4 mode0 storage", 8'(a), model[a]);
    wr(8'd10, 8'h36);
    wr(8'd12, 8'h3C);
    rd_chk("R3 R6 mode0 C write", 8'd12, 8'h3C);
    begin
      logic oe; logic [7:0] d;
      rd(8'd30, oe, d, 1'b1);
      check("R8 mode0 no oe", {8'h0, oe}, 9'h0);
    end

    rst_n = 0; cs_n = 0; ds = 0; gap(4);
    check("R10 oe in reset", {8'h0, ad_oe}, 9'h0);
    cs_n = 1; ds = 1; gap(2);
    rst_n = 1; gap(4);
    rd_chk("R10 A after reset", 8'd10, 8'h00);
    rd_chk("R10 C after reset", 8'd12, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule